// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer

This block remembers where previously executed branches went, so that a fetch pipeline can steer instruction fetch while a branch is still in decode. A lookup presents the branch instruction address and, one cycle later, receives a hit flag, a direction guess and the remembered target. Storage is split into sets of several ways. Each way holds a tag, a target and a two-bit saturating confidence counter. The counter alone decides the direction on a hit. A miss always means sequential fetch.

When a branch resolves in execute, the update port reports its address, its length in bytes, the real outcome, the real target and the guess that was made for it. The buffer refreshes or allocates the entry and compares outcome with guess. If they disagree, it raises a one-cycle flush so that fetch drops younger work and restarts at the corrected address. Both ports accept a request in every cycle and there is no back-pressure. A lookup result is qualified by its own valid pulse and must be consumed in the cycle it appears.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every entry is invalid, and `flush` and `lk_res_valid` are 0.
- R2: `lk_res_valid` equals the value `lk_valid` had in the previous cycle, and the lookup outputs belong to that request.
- R3: A lookup hits when a valid way of the set selected by the low 6 address bits has a tag equal to the remaining address bits. On a hit, `lk_target` is the stored target and `lk_taken` is 1 exactly when the counter is 2 or 3. On a miss, `lk_hit` and `lk_taken` are 0.
- R4: An update that resolves taken and misses allocates an entry with the given target and a counter of 3, so that a later lookup hits and predicts taken.
- R5: An update that resolves not taken and misses allocates nothing, and a later lookup of that address misses.
- R6: An update that hits increments the counter when taken and decrements it when not taken, saturating at 3 and at 0.
- R7: A taken update that hits overwrites the stored target with the resolved target.
- R8: A mispredict raises `flush` for exactly the cycle after the update. A mispredict is a resolved direction that differs from the guess, or a taken-and-guessed-taken branch whose resolved target differs from the guessed target.
- R9: With `flush`, `flush_pc` is the resolved target for a taken branch, and the branch address plus `upd_len` for a not-taken branch.
- R10: An allocation uses the lowest-numbered invalid way of the set. When all ways are valid it uses the way picked by a 3-bit binary-tree pseudo-LRU, which every allocation and every updating hit marks as most recently used. Lookups do not change the pseudo-LRU state.
- R11: A lookup and an update in the same cycle are both serviced, and the lookup sees the contents from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_pc | input | 32 | Address of the branch being decoded |
| lk_res_valid | output | 1 | Lookup result present |
| lk_hit | output | 1 | Matching entry found |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | 32 | Stored target (0 on a miss) |
| upd_valid | input | 1 | Resolved branch present |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_len | input | 4 | Length of the branch instruction in bytes |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | 32 | Resolved target |
| upd_pred_taken | input | 1 | Direction that was guessed |
| upd_pred_target | input | 32 | Target that was guessed |
| flush | output | 1 | Discard younger work and restart |
| flush_pc | output | 32 | Restart address |

## Verification
A lookup result and a flush each appear one clock edge after the request is taken. The counter, target and replacement state that an update writes can be seen by the first lookup issued after that edge. The bench drives every request at a falling edge and samples the outputs at the next falling edge, which lies between the edge that registers the result and the edge that would replace it. Effects on stored state are checked with lookups issued after the update has completed. Same-cycle behaviour is checked by issuing both requests at the same falling edge.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_ALLOC = 2'd3;

  // saturating confidence step
  function automatic ctr_t ctr_step(ctr_t c, logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    else    return (c == 2'd0) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/btb_match.sv
module btb_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 26,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           key,
  output logic                       hit,
  output logic [WAY_W-1:0]           way
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = valid[w] && (tags[w] == key);
  end

  always_comb begin
    hit = |eq;
    way = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (eq[w]) way = WAY_W'(w);
  end
endmodule

// File: rtl/btb_plru.sv
module btb_plru #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int BITS  = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WAYS-1:0]  valid,
  input  logic [BITS-1:0]  state_in,
  input  logic [WAY_W-1:0] touch,
  output logic [WAY_W-1:0] victim,
  output logic [BITS-1:0]  state_out
);
  logic             any_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] tree_way;

  always_comb begin
    any_free = ~&valid;
    free_way = '0;
    for (int w = WAYS-1; w >= 0; w--)
      if (!valid[w]) free_way = WAY_W'(w);
  end

  // walk the tree: each node bit names the colder half
  always_comb begin
    int node;
    node = 1;
    for (int l = 0; l < WAY_W; l++)
      node = 2*node + int'(state_in[node-1]);
    tree_way = WAY_W'(node - WAYS);
  end

  // point every node on the touched path away from it
  always_comb begin
    int node;
    logic b;
    state_out = state_in;
    node = 1;
    for (int l = WAY_W-1; l >= 0; l--) begin
      b = touch[l];
      state_out[node-1] = ~b;
      node = 2*node + int'(b);
    end
  end

  assign victim = any_free ? free_way : tree_way;

  p_free_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    any_free |-> !valid[victim]);
endmodule

// File: rtl/btb_redirect.sv
module btb_redirect #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [LEN_W-1:0]  len,
  input  logic              taken,
  input  logic [ADDR_W-1:0] target,
  input  logic              pred_taken,
  input  logic [ADDR_W-1:0] pred_target,
  output logic              mispredict,
  output logic [ADDR_W-1:0] restart_pc
);
  always_comb begin
    mispredict = (taken != pred_taken) ||
                 (taken && pred_taken && (target != pred_target));
    restart_pc = taken ? target : pc + ADDR_W'(len);
  end
endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 4,
  parameter int ENTRIES = 256,
  parameter int WAYS    = 4,
  localparam int SETS   = ENTRIES / WAYS,
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int PL_W   = WAYS - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              lk_res_valid,
  output logic              lk_hit,
  output logic              lk_taken,
  output logic [ADDR_W-1:0] lk_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [LEN_W-1:0]  upd_len,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_pred_taken,
  input  logic [ADDR_W-1:0] upd_pred_target,
  output logic              flush,
  output logic [ADDR_W-1:0] flush_pc
);
  import btb_pkg::*;

  logic [WAYS-1:0]             valid_q [SETS];
  logic [WAYS-1:0][1:0]        ctr_q   [SETS];
  logic [PL_W-1:0]             plru_q  [SETS];
  logic [WAYS-1:0][TAG_W-1:0]  tag_q   [SETS];
  logic [WAYS-1:0][ADDR_W-1:0] tgt_q   [SETS];

  // lookup side
  logic [IDX_W-1:0] lk_idx;
  logic [TAG_W-1:0] lk_tag;
  logic             lk_m_hit;
  logic [WAY_W-1:0] lk_m_way;

  assign lk_idx = lk_pc[IDX_W-1:0];
  assign lk_tag = lk_pc[ADDR_W-1:IDX_W];

  btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .valid(valid_q[lk_idx]), .tags(tag_q[lk_idx]), .key(lk_tag),
    .hit(lk_m_hit), .way(lk_m_way)
  );

  // update side
  logic [IDX_W-1:0] up_idx;
  logic [TAG_W-1:0] up_tag;
  logic             up_hit;
  logic [WAY_W-1:0] up_way;
  logic [WAY_W-1:0] up_victim;
  logic [WAY_W-1:0] wr_way;
  logic [PL_W-1:0]  plru_next;
  logic             do_write;
  logic             mispredict;
  logic [ADDR_W-1:0] restart_pc;

  assign up_idx = upd_pc[IDX_W-1:0];
  assign up_tag = upd_pc[ADDR_W-1:IDX_W];

  btb_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_up_match (
    .valid(valid_q[up_idx]), .tags(tag_q[up_idx]), .key(up_tag),
    .hit(up_hit), .way(up_way)
  );

  assign wr_way   = up_hit ? up_way : up_victim;
  assign do_write = upd_valid && (up_hit || upd_taken);

  btb_plru #(.WAYS(WAYS)) u_plru (
    .clk(clk), .rst_n(rst_n),
    .valid(valid_q[up_idx]), .state_in(plru_q[up_idx]), .touch(wr_way),
    .victim(up_victim), .state_out(plru_next)
  );

  btb_redirect #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_redirect (
    .pc(upd_pc), .len(upd_len), .taken(upd_taken), .target(upd_target),
    .pred_taken(upd_pred_taken), .pred_target(upd_pred_target),
    .mispredict(mispredict), .restart_pc(restart_pc)
  );

  // state with reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        ctr_q[s]   <= '0;
        plru_q[s]  <= '0;
      end
      lk_res_valid <= 1'b0;
      lk_hit       <= 1'b0;
      lk_taken     <= 1'b0;
      lk_target    <= '0;
      flush        <= 1'b0;
      flush_pc     <= '0;
    end else begin
      lk_res_valid <= lk_valid;
      lk_hit       <= lk_valid && lk_m_hit;
      lk_taken     <= lk_valid && lk_m_hit && ctr_q[lk_idx][lk_m_way][1];
      lk_target    <= (lk_valid && lk_m_hit) ? tgt_q[lk_idx][lk_m_way] : '0;
      flush        <= upd_valid && mispredict;
      flush_pc     <= (upd_valid && mispredict) ? restart_pc : flush_pc;
      if (do_write) begin
        valid_q[up_idx][wr_way] <= 1'b1;
        ctr_q[up_idx][wr_way]   <= up_hit ? ctr_step(ctr_q[up_idx][wr_way], upd_taken)
                                          : CTR_ALLOC;
        plru_q[up_idx]          <= plru_next;
      end
    end
  end

  // payload without reset
  always_ff @(posedge clk) begin
    if (do_write && upd_taken) begin
      tag_q[up_idx][wr_way] <= up_tag;
      tgt_q[up_idx][wr_way] <= upd_target;
    end
  end

  p_res_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> lk_res_valid);
  p_res_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !lk_res_valid);
  p_taken_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_taken |-> lk_hit);
  p_flush_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flush) |-> $past(upd_valid));
  p_taken_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && upd_pred_taken == 1'b0) |=> (flush && flush_pc == $past(upd_target)));
endmodule

// File: tb/sim_branch_target_buffer.sv
module sim_branch_target_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_res_valid, lk_hit, lk_taken;
  logic [31:0] lk_target;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [3:0]  upd_len = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic        upd_pred_taken = 1'b0;
  logic [31:0] upd_pred_target = '0;
  logic        flush;
  logic [31:0] flush_pc;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  branch_target_buffer u0 (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_res_valid(lk_res_valid),
    .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_len(upd_len),
    .upd_taken(upd_taken), .upd_target(upd_target),
    .upd_pred_taken(upd_pred_taken), .upd_pred_target(upd_pred_target),
    .flush(flush), .flush_pc(flush_pc)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] pc, input bit e_hit, input bit e_tk,
                        input logic [31:0] e_tgt, input string rq);
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = pc;
    @(negedge clk);
    lk_valid = 1'b0;
    chk(lk_res_valid == 1'b1, {rq, " res_valid"}, 32'(lk_res_valid), 32'd1);
    chk(lk_hit == e_hit, {rq, " hit"}, 32'(lk_hit), 32'(e_hit));
    chk(lk_taken == e_tk, {rq, " taken"}, 32'(lk_taken), 32'(e_tk));
    if (e_hit) chk(lk_target == e_tgt, {rq, " target"}, lk_target, e_tgt);
  endtask

  task automatic update(input logic [31:0] pc, input bit tk, input logic [31:0] tgt,
                        input bit ptk, input logic [31:0] ptgt,
                        input bit e_fl, input logic [31:0] e_fpc, input string rq);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_len = 4'd2; upd_taken = tk;
    upd_target = tgt; upd_pred_taken = ptk; upd_pred_target = ptgt;
    @(negedge clk);
    upd_valid = 1'b0;
    chk(flush == e_fl, {rq, " flush"}, 32'(flush), 32'(e_fl));
    if (e_fl) chk(flush_pc == e_fpc, {rq, " flush_pc"}, flush_pc, e_fpc);
  endtask

  localparam logic [31:0] A  = 32'h1000_0040;
  localparam logic [31:0] T  = 32'h2000_0100;
  localparam logic [31:0] T2 = 32'h2000_0200;
  localparam logic [31:0] B  = 32'h1000_0081;
  localparam logic [31:0] G  = 32'h5000_0007;

  task automatic t_reset;
    chk(flush == 1'b0, "R1 flush after reset", 32'(flush), 32'd0);
    chk(lk_res_valid == 1'b0, "R1 res_valid after reset", 32'(lk_res_valid), 32'd0);
    lookup(A, 0, 0, 0, "R1 empty buffer");
    @(negedge clk);
    chk(lk_res_valid == 1'b0, "R2 idle cycle", 32'(lk_res_valid), 32'd0);
  endtask

  task automatic t_alloc;
    update(A, 1, T, 0, 0, 1, T, "R4 R8 R9 first taken");
    lookup(A, 1, 1, T, "R4 R3 allocated entry");
    update(B, 0, 0, 0, 0, 0, 0, "R5 not-taken miss");
    lookup(B, 0, 0, 0, "R5 no allocation");
  endtask

  task automatic t_counter;
    update(A, 0, 0, 1, T, 1, A + 32'd2, "R9 fall-through");   // 3->2
    lookup(A, 1, 1, T, "R6 counter 2");
    update(A, 0, 0, 1, T, 1, A + 32'd2, "R8 nt mispredict");  // 2->1
    lookup(A, 1, 0, T, "R6 R3 counter 1 weak");
    update(A, 0, 0, 0, 0, 0, 0, "R8 correct nt");            // 1->0
    update(A, 0, 0, 0, 0, 0, 0, "R6 floor");                 // 0->0
    update(A, 1, T, 0, 0, 1, T, "R9 taken redirect");        // 0->1
    lookup(A, 1, 0, T, "R6 saturate at 0");
    update(A, 1, T, 0, 0, 1, T, "R8 taken");                 // 1->2
    lookup(A, 1, 1, T, "R6 counter 2 again");
    update(A, 1, T, 1, T, 0, 0, "R8 correct taken");         // 2->3
    update(A, 1, T, 1, T, 0, 0, "R6 ceiling");               // 3->3
    update(A, 0, 0, 1, T, 1, A + 32'd2, "R9 nt after ceiling"); // 3->2
    lookup(A, 1, 1, T, "R6 saturate at 3");
  endtask

  task automatic t_target;
    update(A, 1, T2, 1, T, 1, T2, "R8 R7 wrong target");
    lookup(A, 1, 1, T2, "R7 target rewritten");
  endtask

  task automatic t_replace;
    for (int k = 0; k < 4; k++)
      update(32'h3000_0005 + 32'(k*64), 1, 32'h4000_0000 + 32'(k*16), 0, 0,
             1, 32'h4000_0000 + 32'(k*16), "R10 fill");
    for (int k = 0; k < 4; k++)
      lookup(32'h3000_0005 + 32'(k*64), 1, 1, 32'h4000_0000 + 32'(k*16), "R10 all ways held");
    update(32'h3000_0105, 1, 32'h4000_0040, 0, 0, 1, 32'h4000_0040, "R10 fifth");
    lookup(32'h3000_0005, 0, 0, 0, "R10 oldest evicted");
    lookup(32'h3000_0105, 1, 1, 32'h4000_0040, "R10 new way");
    update(32'h3000_0045, 1, 32'h4000_0010, 1, 32'h4000_0010, 0, 0, "R10 touch");
    update(32'h3000_0145, 1, 32'h4000_0050, 0, 0, 1, 32'h4000_0050, "R10 sixth");
    lookup(32'h3000_0085, 0, 0, 0, "R10 plru victim");
    lookup(32'h3000_0045, 1, 1, 32'h4000_0010, "R10 touched kept");
    lookup(32'h3000_00C5, 1, 1, 32'h4000_0030, "R10 kept");
    lookup(32'h3000_0145, 1, 1, 32'h4000_0050, "R10 sixth held");
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    lk_valid = 1'b1; lk_pc = G;
    upd_valid = 1'b1; upd_pc = G; upd_len = 4'd2; upd_taken = 1'b1;
    upd_target = 32'h6000_0000; upd_pred_taken = 1'b0; upd_pred_target = '0;
    @(negedge clk);
    lk_valid = 1'b0; upd_valid = 1'b0;
    chk(lk_res_valid == 1'b1, "R11 res_valid", 32'(lk_res_valid), 32'd1);
    chk(lk_hit == 1'b0, "R11 sees old contents", 32'(lk_hit), 32'd0);
    chk(flush == 1'b1, "R11 update serviced", 32'(flush), 32'd1);
    lookup(G, 1, 1, 32'h6000_0000, "R11 update landed");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_counter();
    t_target();
    t_replace();
    t_same_cycle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule